// File: doc/BRIEF.md
# Selectable Power-of-Two Clock Divider

This block divides an incoming clock by 1, 2, 4 or 8. A chain of three binary counter stages advances on every falling edge of the input clock. A two-bit select code picks what reaches the output: the input clock itself, or one of the three stage outputs. Each divided output has a 50% duty cycle. The output pin is tri-state. The block also drives an enable line to the upstream clock source, so that the source can be halted.

A single active-low master reset acts asynchronously. While the reset is low, it clears the counter, floats the output and withdraws the clock-source enable. Each select pin has a companion "driven" flag that models a pin left unconnected. An undriven select pin reads as 1, so a fully unconnected select defaults to the slowest rate. The select code can change at any time. The change reaches the output multiplexer at once and leaves the counter running.

Top module: `clkdiv_sel`

## Requirements
- R1: The select code on `sel` (bit 1 is the high bit) chooses the output rate: 0 passes the input clock straight through, 1 divides by 2, 2 divides by 4 and 3 divides by 8.
- R2: The counter changes state only on a falling edge of `clkIn`, and stage 0 toggles on every such edge while reset is high.
- R3: Stage k (k ≥ 1) toggles on a falling edge only when all lower stages were 1 before that edge, so the stages form a binary up-count that wraps from 7 to 0. The divided output for code k comes from stage k−1.
- R4: While `rstN` is low, and at once when it falls, three things hold: the counter is cleared, `outEn` and `srcRun` are low, and `clkOut` is high impedance.
- R5: When `rstN` rises, `outEn` and `srcRun` go high at once. With code 0 selected and `clkIn` high, `clkOut` is high at once.
- R6: A select bit whose `selDriven` flag is 0 reads as 1, whatever the value on `sel`. With both flags at 0 the block divides by 8.
- R7: A select change appears on `clkOut` at once and does not disturb the counter value.
- R8: After reset is released, the count restarts from zero. The first falling edge sets stage 0, and the divided outputs read 0 before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkIn | input | 1 | Clock to be divided; the counter steps on its falling edge |
| rstN | input | 1 | Asynchronous master reset, active low |
| sel | input | 2 | Rate select code; bit 1 is the high bit |
| selDriven | input | 2 | Per-bit flag: 1 when the matching select pin is driven, 0 when it is left open |
| clkOut | output | 1 | Divided clock; high impedance while disabled |
| outEn | output | 1 | High while `clkOut` is driven |
| srcRun | output | 1 | Run enable to the upstream clock source |

## Verification
A corrupted counter stage shows up on `clkOut` as soon as that stage's code is selected. The divided output then sits at the wrong level within one falling edge of the fault, and the edge count over a 64-cycle window comes out wrong. A select decode that ignores the open-pin default, or that clears the counter on a code change, is visible one nanosecond after the change: the output level differs from the level implied by the count reached so far. A reset path that is not asynchronous leaves `outEn` or `srcRun` high after `rstN` falls, before any clock edge arrives.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  // Width of the select code; the number of counter stages follows from it.
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned STAGES = (1 << SEL_W) - 1;
  localparam int unsigned TAPS   = STAGES + 1;

  typedef logic [SEL_W-1:0] tap_t;

  // Named rates for the select code.
  typedef enum logic [SEL_W-1:0] {
    RATE_FULL = 0,
    RATE_HALF = 1,
    RATE_QUARTER = 2,
    RATE_EIGHTH = 3
  } rate_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic outDrive;
    tap_t tap;
  } strobe_t;
endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
(
  input  logic             rstN,
  input  logic [SEL_W-1:0] sel,
  input  logic [SEL_W-1:0] selDriven,
  output strobe_t          strobe,
  output logic             srcRun
);
  tap_t selEff;

  // Each open select pin is pulled to 1.
  for (genvar i = 0; i < SEL_W; i++) begin : g_pull
    assign selEff[i] = selDriven[i] ? sel[i] : 1'b1;
  end

  always_comb begin
    strobe.outDrive = rstN;
    strobe.tap      = selEff;
  end

  assign srcRun = rstN;
endmodule

// File: rtl/clkdiv_dp.sv
module clkdiv_dp
  import clkdiv_pkg::*;
(
  input  logic    clkIn,
  input  logic    rstN,
  input  strobe_t strobe,
  output logic    clkOut,
  output logic    outEn
);
  logic [STAGES-1:0] stageQ;
  logic [TAPS-1:0]   tapVec;
  logic              muxOut;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic carry;
    logic q;
    if (k == 0) begin : g_first
      assign carry = 1'b1;
    end else begin : g_rest
      assign carry = &stageQ[k-1:0];
      // R3: a higher stage moves only when every lower stage was 1.
      p_carry_r3: assert property (@(posedge clkIn) disable iff (!rstN)
        ($past(rstN) && (stageQ[k] != $past(stageQ[k]))) |-> (&$past(stageQ[k-1:0])))
        else $error("stage %0d toggled without carry", k);
    end

    always_ff @(negedge clkIn or negedge rstN) begin
      if (!rstN)      q <= 1'b0;
      else if (carry) q <= ~q;
    end
    assign stageQ[k] = q;
  end

  // Tap 0 is the undivided clock; tap k is stage k-1.
  assign tapVec = {stageQ, clkIn};
  assign muxOut = tapVec[strobe.tap];
  assign clkOut = strobe.outDrive ? muxOut : 1'bz;
  assign outEn  = strobe.outDrive;

  // R2: stage 0 flips once per input period while running.
  p_stage0_step_r2: assert property (@(posedge clkIn) disable iff (!rstN)
    $past(rstN) |-> (stageQ[0] != $past(stageQ[0])))
    else $error("stage 0 did not toggle");

  // R4: the counter holds zero while reset is low.
  p_cleared_r4: assert property (@(posedge clkIn) disable iff (rstN)
    stageQ == '0)
    else $error("counter not cleared in reset");
endmodule

// File: rtl/clkdiv_sel.sv
module clkdiv_sel
  import clkdiv_pkg::*;
(
  input  logic             clkIn,
  input  logic             rstN,
  input  logic [SEL_W-1:0] sel,
  input  logic [SEL_W-1:0] selDriven,
  output logic             clkOut,
  output logic             outEn,
  output logic             srcRun
);
  strobe_t strobe;

  clkdiv_ctrl u_ctrl (
    .rstN      (rstN),
    .sel       (sel),
    .selDriven (selDriven),
    .strobe    (strobe),
    .srcRun    (srcRun)
  );

  clkdiv_dp u_dp (
    .clkIn  (clkIn),
    .rstN   (rstN),
    .strobe (strobe),
    .clkOut (clkOut),
    .outEn  (outEn)
  );

  // R4: output and source enable are off throughout reset.
  p_quiet_reset_r4: assert property (@(posedge clkIn) disable iff (rstN)
    !outEn && !srcRun)
    else $error("enables active during reset");

  // R6: a fully open select lands on the slowest tap.
  p_float_max_r6: assert property (@(posedge clkIn) disable iff (!rstN)
    (selDriven == '0) |-> (strobe.tap == '1))
    else $error("open select did not default to slowest rate");

  // R5: both enables are up whenever reset is released.
  p_run_out_r5: assert property (@(posedge clkIn) disable iff (!rstN)
    outEn && srcRun)
    else $error("enables low outside reset");
endmodule

// File: tb/clkdiv_sel_test.sv
module clkdiv_sel_test;
  import clkdiv_pkg::*;

  logic       clkIn = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] sel = RATE_FULL;
  logic [1:0] selDriven = 2'b11;
  logic       clkOut;
  logic       outEn;
  logic       srcRun;

  int checks = 0;
  int fails = 0;
  int expQ[$];
  string reqQ[$];
  int edgeCnt = 0;
  logic winOpen = 1'b0;
  event winDone;
  bit finished = 0;

  always #10 clkIn = ~clkIn;

  clkdiv_sel uut (
    .clkIn     (clkIn),
    .rstN      (rstN),
    .sel       (sel),
    .selDriven (selDriven),
    .clkOut    (clkOut),
    .outEn     (outEn),
    .srcRun    (srcRun)
  );

  always @(posedge clkOut) if (winOpen) edgeCnt++;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wrapUp();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Monitor: pops the expected edge count when a window closes.
  initial forever begin
    @(winDone);
    check(reqQ.pop_front(), edgeCnt, expQ.pop_front());
  end

  // Driver: sets the select, pushes the expectation, opens a 64-cycle window.
  task automatic measure(string req, logic [1:0] s, logic [1:0] drv, int exp);
    sel = s;
    selDriven = drv;
    repeat (4) @(posedge clkIn);
    #5;
    expQ.push_back(exp);
    reqQ.push_back(req);
    edgeCnt = 0;
    winOpen = 1'b1;
    #(64 * 20);
    winOpen = 1'b0;
    ->winDone;
    #1;
  endtask

  initial begin
    #(200000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    wrapUp();
  end

  initial begin
    #3;
    check("R4 outEn in reset", int'(outEn), 0);
    check("R4 srcRun in reset", int'(srcRun), 0);

    // Release with clkIn high in straight-through mode.
    @(posedge clkIn); #2 rstN = 1'b1;
    #1;
    check("R5 outEn after release", int'(outEn), 1);
    check("R5 srcRun after release", int'(srcRun), 1);
    check("R5 clkOut follows high clkIn", int'(clkOut), 1);

    measure("R1 code 0 rate", RATE_FULL, 2'b11, 64);
    measure("R1 code 1 rate", RATE_HALF, 2'b11, 32);
    measure("R1 code 2 rate", RATE_QUARTER, 2'b11, 16);
    measure("R1 code 3 rate", RATE_EIGHTH, 2'b11, 8);
    measure("R6 both pins open", RATE_FULL, 2'b00, 8);
    measure("R6 low pin open", RATE_FULL, 2'b10, 32);
    measure("R6 high pin open", RATE_FULL, 2'b01, 16);

    // Asynchronous reset mid-run, then a counted restart.
    sel = RATE_HALF;
    selDriven = 2'b11;
    @(negedge clkIn); #3 rstN = 1'b0;
    #1;
    check("R4 outEn drops at once", int'(outEn), 0);
    check("R4 srcRun drops at once", int'(srcRun), 0);
    @(posedge clkIn); #2 rstN = 1'b1;
    #1;
    check("R8 half output zero after release", int'(clkOut), 0);
    @(negedge clkIn); #2;
    check("R2 first falling edge sets stage 0", int'(clkOut), 1);
    @(posedge clkIn); #2;
    check("R2 rising edge leaves count", int'(clkOut), 1);
    @(negedge clkIn); @(negedge clkIn); #2;   // count is 3
    sel = RATE_QUARTER;
    #1;
    check("R7 switch to quarter keeps count", int'(clkOut), 1);
    sel = RATE_EIGHTH;
    #1;
    check("R7 switch to eighth keeps count", int'(clkOut), 0);
    repeat (4) @(negedge clkIn);
    #2;                                        // count is 7
    check("R3 stage 2 set at count 7", int'(clkOut), 1);
    @(negedge clkIn); #2;                      // wraps to 0
    check("R3 wrap clears stage 2", int'(clkOut), 0);
    sel = RATE_QUARTER;
    #1;
    check("R3 wrap clears stage 1", int'(clkOut), 0);

    wrapUp();
  end
endmodule